// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block drives the command bus of a DDR SDRAM from reset to the ready state. After reset it holds clock enable low for the power-up delay. The delay is counted in clock cycles and derived from a clock-frequency parameter. It then issues a fixed series of commands: a NOP with clock enable raised, and a precharge of all banks. Next come three mode loads: an extended-mode load that enables the DLL, a base-mode load with the DLL-reset bit set, and, after a second all-bank precharge and two auto-refreshes, a final base-mode load with that bit cleared. NOPs fill the gaps between commands so that each command is followed by its own recovery time. Chip select stays high in every cycle that has no command.

Two flags tell the memory controller where the sequence stands. `init_done` rises once the final mode load and its recovery time have both completed. `read_ok` has its own timer, which starts at the DLL-reset load and covers the DLL lock interval, so it shows when a READ would first be legal. A synchronous reset restarts the whole sequence from the clock-enable-low wait.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset is released, `cke` stays low for exactly PWR cycles, where PWR = (CLK_HZ/1_000_000)*POWERUP_US. The first command follows in the next cycle with `cke` high.
- R2: While `cke` is low, `cs_n` is 1. Once `cke` has risen, it stays high until the next reset.
- R3: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as NOP=0111, PRECHARGE=0010, AUTO REFRESH=0001 and LOAD MODE=0000. They are issued in this order: NOP, PRECHARGE, LOAD MODE, LOAD MODE, PRECHARGE, AUTO REFRESH, AUTO REFRESH, LOAD MODE.
- R4: Every PRECHARGE drives address bit 10 high, which selects all banks.
- R5: The first LOAD MODE targets the extended register with `ba`=2'b01 and `addr`=EMR_VAL. Bit 0 of EMR_VAL is 0, which enables the DLL.
- R6: The second LOAD MODE targets the base register with `ba`=2'b00 and `addr`=MR_VAL with bit 8 (DLL reset) set.
- R7: The last LOAD MODE targets the base register with `ba`=2'b00 and `addr`=MR_VAL with bit 8 cleared.
- R8: Consecutive commands are spaced, issue to issue, by 1 cycle after the NOP, T_RP after each PRECHARGE, T_MRD after each LOAD MODE and T_RFC after each AUTO REFRESH.
- R9: `init_done` rises exactly T_MRD cycles after the last LOAD MODE. It then stays high until reset.
- R10: `read_ok` rises exactly DLL_LOCK cycles after the DLL-reset LOAD MODE. It then stays high until reset.
- R11: While `rst` is high, and in the cycle after it, `cke`, `init_done` and `read_ok` are low and `cs_n` is 1. When `rst` is released, the full sequence restarts from R1, even if reset came in the middle of a sequence.
- R12: `cs_n` is 1 in every cycle without a command, including all cycles after `init_done`. Exactly eight commands are issued per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ROW_W | Address / mode value |
| init_done | output | 1 | Sequence complete |
| read_ok | output | 1 | DLL lock interval has elapsed |

## Verification
Some properties hold on every cycle, and assertions check them. No command may be issued with clock enable low, and clock enable never falls after it has risen. Every precharge must select all banks. The bus must stay deselected after completion, the two flags must be sticky, and reset must clear the outputs. Other properties depend on the whole sequence, so only the bench's scenarios can show them. These are the exact length of the power-up wait, the order of commands and their spacing, the address and bank values of each mode load, the exact rise cycles of both flags, and a clean restart when reset arrives in the middle of a sequence.

// File: rtl/ddr_init_seq.sv
`timescale 1ns/1ps
module ddr_init_seq #(
  parameter int CLK_HZ      = 200_000_000,
  parameter int POWERUP_US  = 200,
  parameter int T_RP        = 3,
  parameter int T_MRD       = 2,
  parameter int T_RFC       = 14,
  parameter int DLL_LOCK    = 200,
  parameter int ROW_W       = 13,
  parameter int BA_W        = 2,
  parameter int DLL_RST_BIT = 8,
  parameter int AP_BIT      = 10,
  parameter logic [ROW_W-1:0] MR_VAL  = 'h062,
  parameter logic [ROW_W-1:0] EMR_VAL = 'h000
) (
  input  logic             clk,
  input  logic             rst,
  output logic             cke,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr,
  output logic             init_done,
  output logic             read_ok
);
  localparam int PWR_CYC = (CLK_HZ / 1_000_000) * POWERUP_US;
  localparam int M1      = PWR_CYC > T_RFC ? PWR_CYC : T_RFC;
  localparam int M2      = M1 > T_RP ? M1 : T_RP;
  localparam int CNT_MAX = M2 > T_MRD ? M2 : T_MRD;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int LW      = $clog2(DLL_LOCK + 1);
  localparam logic [ROW_W-1:0] RST_MASK = ROW_W'(1) << DLL_RST_BIT;

  typedef enum logic [3:0] {
    S_PWR, S_NOP, S_PRE1, S_EMR, S_MRR, S_PRE2, S_REF1, S_REF2, S_MRF, S_TAIL, S_DONE
  } step_t;

  step_t         step;
  logic [CW-1:0] cnt;
  logic [LW-1:0] lock;
  logic          armed;
  logic          issue;
  int            gap;
  logic [3:0]    cmd;

  assign issue = (step >= S_NOP) && (step <= S_MRF) && (cnt == '0);

  always_comb begin
    case (step)
      S_PRE1, S_PRE2:       gap = T_RP;
      S_EMR, S_MRR, S_MRF:  gap = T_MRD;
      S_REF1, S_REF2:       gap = T_RFC;
      default:              gap = 1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= S_PWR;
      cnt  <= CW'(PWR_CYC - 1);
    end else if (step != S_DONE) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        step <= step_t'(step + 4'd1);
        if (step != S_PWR && step != S_TAIL) cnt <= CW'(gap - 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      lock  <= '0;
    end else if (issue && step == S_MRR) begin
      armed <= 1'b1;
      lock  <= LW'(DLL_LOCK - 1);
    end else if (lock != '0) begin
      lock <= lock - 1'b1;
    end
  end

  always_comb begin
    cmd  = 4'b1111;
    ba   = '0;
    addr = '0;
    if (issue) begin
      case (step)
        S_NOP:          cmd = 4'b0111;
        S_PRE1, S_PRE2: begin cmd = 4'b0010; addr[AP_BIT] = 1'b1; end
        S_REF1, S_REF2: cmd = 4'b0001;
        S_EMR:          begin cmd = 4'b0000; ba = BA_W'(1); addr = EMR_VAL; end
        S_MRR:          begin cmd = 4'b0000; addr = MR_VAL | RST_MASK; end
        S_MRF:          begin cmd = 4'b0000; addr = MR_VAL & ~RST_MASK; end
        default:        cmd = 4'b1111;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke       = (step != S_PWR);
  assign init_done = (step == S_DONE) || (step == S_TAIL && cnt == '0);
  assign read_ok   = armed && (lock == '0);
endmodule

// File: rtl/ddr_init_seq_chk.sv
`timescale 1ns/1ps
module ddr_init_seq_chk #(
  parameter int ROW_W  = 13,
  parameter int AP_BIT = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cke,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [ROW_W-1:0] addr,
  input logic             init_done,
  input logic             read_ok
);
  AST_NO_CMD_CKE_LOW: assert property (@(posedge clk) disable iff (rst) !cke |-> cs_n); // R2
  AST_CKE_HOLDS: assert property (@(posedge clk) disable iff (rst) cke |=> cke); // R2
  AST_PRECHARGE_ALL: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && cas_n && !we_n) |-> addr[AP_BIT]); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) init_done |=> init_done); // R9
  AST_READ_OK_STICKY: assert property (@(posedge clk) disable iff (rst) read_ok |=> read_ok); // R10
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!cke && cs_n && !init_done && !read_ok)); // R11
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst) init_done |-> cs_n); // R12
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ROW_W(ROW_W), .AP_BIT(AP_BIT)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr(addr), .init_done(init_done), .read_ok(read_ok)
);

// File: tb/ddr_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_init_seq_bench;
  localparam int CLK_HZ = 200_000_000;
  localparam int PWR    = (CLK_HZ / 1_000_000) * 200;
  localparam int T_RP = 3, T_MRD = 2, T_RFC = 14, LOCK = 200;
  localparam logic [12:0] MR  = 13'h0062;
  localparam logic [12:0] EMR = 13'h0002;

  logic clk = 1'b0, rst = 1'b1;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, read_ok;
  logic [1:0] ba;
  logic [12:0] addr;

  always #2.5 clk = ~clk;

  ddr_init_seq #(.CLK_HZ(CLK_HZ), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC),
                 .DLL_LOCK(LOCK), .MR_VAL(MR), .EMR_VAL(EMR)) u_ddr_init_seq (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done), .read_ok(read_ok));

  int errors = 0, checks = 0;
  int cyc, lowcnt, ncmd, badcke, ckefall, done_t, rok_t;
  logic [3:0]  c_code [16];
  logic [12:0] c_addr [16];
  logic [1:0]  c_ba   [16];
  int          c_t    [16];
  logic        prev_cke;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; lowcnt = 0; ncmd = 0; badcke = 0; ckefall = 0;
      done_t = -1; rok_t = -1; prev_cke = 1'b0;
    end else begin
      cyc++;
      if (!cke) lowcnt++;
      if (prev_cke && !cke) ckefall++;
      prev_cke = cke;
      if (!cs_n) begin
        if (!cke) badcke++;
        if (ncmd < 16) begin
          c_code[ncmd] = {cs_n, ras_n, cas_n, we_n};
          c_addr[ncmd] = addr; c_ba[ncmd] = ba; c_t[ncmd] = cyc;
        end
        ncmd++;
      end
      if (init_done && done_t < 0) done_t = cyc;
      if (read_ok && rok_t < 0) rok_t = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cke && cs_n && !init_done && !read_ok, "R11 outputs in reset",
        {cke, cs_n, init_done, read_ok}, 4'b0100);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(!cke && cs_n && !init_done && !read_ok, "R11 cycle after release",
        {cke, cs_n, init_done, read_ok}, 4'b0100);
  endtask

  task automatic t_full_run();
    logic [3:0] exp_code [8];
    exp_code = '{4'b0111, 4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'b0001, 4'b0000};
    while (done_t < 0 || rok_t < 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(lowcnt == PWR, "R1 cke low cycles", lowcnt, PWR);
    chk(c_t[0] == PWR + 1, "R1 first command cycle", c_t[0], PWR + 1);
    chk(badcke == 0, "R2 command with cke low", badcke, 0);
    chk(ckefall == 0 && cke, "R2 cke stays high", ckefall, 0);
    chk(ncmd == 8, "R12 command count", ncmd, 8);
    for (int i = 0; i < 8; i++)
      chk(c_code[i] == exp_code[i], "R3 command code", c_code[i], exp_code[i]);
    chk(c_addr[1][10] && c_addr[4][10], "R4 precharge A10", {c_addr[1][10], c_addr[4][10]}, 2'b11);
    chk(c_ba[2] == 2'b01 && c_addr[2] == EMR, "R5 extended load", c_addr[2], EMR);
    chk(c_ba[3] == 2'b00 && c_addr[3] == (MR | 13'h0100), "R6 DLL reset load", c_addr[3], MR | 13'h0100);
    chk(c_ba[7] == 2'b00 && c_addr[7] == (MR & ~13'h0100), "R7 final load", c_addr[7], MR & ~13'h0100);
    chk(c_t[1] - c_t[0] == 1, "R8 gap after NOP", c_t[1] - c_t[0], 1);
    chk(c_t[2] - c_t[1] == T_RP, "R8 gap tRP first", c_t[2] - c_t[1], T_RP);
    chk(c_t[3] - c_t[2] == T_MRD, "R8 gap tMRD ext", c_t[3] - c_t[2], T_MRD);
    chk(c_t[4] - c_t[3] == T_MRD, "R8 gap tMRD reset", c_t[4] - c_t[3], T_MRD);
    chk(c_t[5] - c_t[4] == T_RP, "R8 gap tRP second", c_t[5] - c_t[4], T_RP);
    chk(c_t[6] - c_t[5] == T_RFC, "R8 gap tRFC first", c_t[6] - c_t[5], T_RFC);
    chk(c_t[7] - c_t[6] == T_RFC, "R8 gap tRFC second", c_t[7] - c_t[6], T_RFC);
    chk(done_t - c_t[7] == T_MRD, "R9 done delay", done_t - c_t[7], T_MRD);
    chk(init_done, "R9 done held", init_done, 1);
    chk(rok_t - c_t[3] == LOCK, "R10 read_ok delay", rok_t - c_t[3], LOCK);
    chk(read_ok, "R10 read_ok held", read_ok, 1);
    chk(cs_n, "R12 deselect after done", cs_n, 1);
  endtask

  task automatic t_restart_mid();
    while (ncmd < 5) @(negedge clk);
    chk(!read_ok && !init_done, "R10 flags low mid sequence", {read_ok, init_done}, 0);
    t_reset_state();
    chk(ncmd == 0 && !cke, "R11 restart from power wait", ncmd, 0);
  endtask

  initial begin
    #950_000;
    errors++; checks++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_full_run();
    t_reset_state();
    t_restart_mid();
    t_full_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule